// File: doc/BRIEF.md
# Mode-Selectable Serial Shift Register

This block holds one byte that is moved bit by bit to or from a serial line. A 3-bit mode input sets two things at once: the direction of the move and the event that advances it. The event can be a strobe from an external down-counter, every system clock, or a rising edge on an asynchronous clock pin. The pin is synchronized inside the block. A bit counter is armed to eight whenever software reads or writes the data byte. It drops by one on each shift, and a sticky completion flag goes high on the eighth shift.

Software loads a byte through the write port and picks an output mode. It then waits for the completion flag while the byte leaves most significant bit first on the serial output. Shifted-out bits re-enter at the bottom, so after eight shifts the byte is back where it started. To receive, software picks an input mode and reads the byte once the flag is set. The read also re-arms the counter for the next byte. One output mode, driven by the strobe, keeps circulating after the count runs out. A host can use it to send a repeating pattern.

Top module: `shreg_shift_unit`

## Requirements
- R1: After reset the data byte is 0x00, the completion flag is 0, the serial output is 0 and the counter is armed for eight shifts.
- R2: In mode 0 no shift ever happens: the data byte keeps its value whatever the strobe, pin and serial input do.
- R3: Modes 1, 2 and 3 shift in. On each shift the byte moves one place toward bit 7 and the serial input enters at bit 0.
- R4: Modes 4, 5, 6 and 7 shift out. On each shift the serial output takes the old bit 7 and the byte rotates one place toward bit 7, with the old bit 7 entering bit 0.
- R5: The shift event depends on the mode. Modes 1, 4 and 5 shift in a cycle where the strobe input is 1. Modes 2 and 6 shift on every clock. Modes 3 and 7 shift on the third clock edge after the pin rises. A falling edge on the pin causes no shift.
- R6: Each shift lowers the counter by one. The completion flag goes to 1 on the shift that takes it from 1 to 0, and it stays 1 until the next data access.
- R7: A write stores the byte, re-arms the counter to eight and clears the flag. A write takes priority over a shift in the same cycle.
- R8: A read returns the byte unchanged, re-arms the counter to eight and clears the flag. No shift happens in the cycle of the read.
- R9: Once the counter is zero, every mode except 5 stops shifting, and the byte holds.
- R10: In mode 5 the byte keeps rotating on every strobe after the counter reaches zero, and the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Direction and shift event select |
| wr_en_i | input | 1 | Write strobe for the data byte |
| wr_data_i | input | 8 | Byte to store |
| rd_en_i | input | 1 | Read strobe for the data byte |
| rd_data_o | output | 8 | Current data byte |
| t2_strobe_i | input | 1 | One-cycle underflow strobe from the external counter |
| ext_clk_i | input | 1 | Asynchronous shift clock pin |
| ser_in_i | input | 1 | Serial data in |
| ser_out_o | output | 1 | Serial data out, registered |
| done_o | output | 1 | Eight-shift completion flag |

## Verification
A write or read shows in the byte and in the flag one clock after the strobe is seen. A strobe shift or system clock shift shows one clock later as well. A pin edge shows three clocks after the pin rises, because it passes two synchronizer stages and an edge register first. The bench drives every input just after a falling edge and samples just before the next falling edge. It counts rising edges from the stimulus exactly, so it reads each result in the first cycle it is due and never a cycle early. Flag checks on the seventh and eighth shifts after a re-arm pin the count to the exact edge.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [2:0] {
        SM_OFF         = 3'd0,
        SM_IN_T2       = 3'd1,
        SM_IN_SYS      = 3'd2,
        SM_IN_EXT      = 3'd3,
        SM_OUT_T2      = 3'd4,
        SM_OUT_T2_FREE = 3'd5,
        SM_OUT_SYS     = 3'd6,
        SM_OUT_EXT     = 3'd7
    } shift_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_T2,
        SRC_SYS,
        SRC_EXT
    } clk_src_e;

    typedef struct packed {
        logic     dir_out;
        logic     free_run;
        clk_src_e src;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [2:0] m);
        mode_dec_t d;
        d.dir_out  = m[2];
        d.free_run = (m == SM_OUT_T2_FREE);
        case (m)
            SM_IN_T2, SM_OUT_T2, SM_OUT_T2_FREE: d.src = SRC_T2;
            SM_IN_SYS, SM_OUT_SYS:               d.src = SRC_SYS;
            SM_IN_EXT, SM_OUT_EXT:               d.src = SRC_EXT;
            default:                             d.src = SRC_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/shreg_edge_sync.sv
module shreg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-1:0], async_i};
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/shreg_tick_sel.sv
module shreg_tick_sel
    import shreg_pkg::*;
(
    input  mode_dec_t dec_i,
    input  logic      t2_strobe_i,
    input  logic      ext_rise_i,
    output logic      tick_o
);
    always_comb begin
        case (dec_i.src)
            SRC_T2:  tick_o = t2_strobe_i;
            SRC_SYS: tick_o = 1'b1;
            SRC_EXT: tick_o = ext_rise_i;
            default: tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/shreg_core.sv
module shreg_core
    import shreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_dec_t        dec_i,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic             ser_in_i,
    output logic [WIDTH-1:0] data_o,
    output logic             ser_out_o,
    output logic             done_o
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [WIDTH-1:0] data_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             ser_q;
    logic             armed;
    logic             do_shift;

    assign armed    = (cnt_q != '0) || dec_i.free_run;
    assign do_shift = tick_i && armed && (dec_i.src != SRC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            cnt_q  <= CNT_FULL;
            done_q <= 1'b0;
            ser_q  <= 1'b0;
        end else if (wr_en_i) begin
            data_q <= wr_data_i;
            cnt_q  <= CNT_FULL;
            done_q <= 1'b0;
        end else if (rd_en_i) begin
            cnt_q  <= CNT_FULL;
            done_q <= 1'b0;
        end else if (do_shift) begin
            if (dec_i.dir_out) begin
                ser_q  <= data_q[WIDTH-1];
                data_q <= {data_q[WIDTH-2:0], data_q[WIDTH-1]};
            end else begin
                data_q <= {data_q[WIDTH-2:0], ser_in_i};
            end
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_ONE;
                if (cnt_q == CNT_ONE) done_q <= 1'b1;
            end
        end
    end

    assign data_o    = data_q;
    assign ser_out_o = ser_q;
    assign done_o    = done_q;
endmodule

// File: rtl/shreg_shift_unit.sv
module shreg_shift_unit
    import shreg_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    output logic [WIDTH-1:0] rd_data_o,
    input  logic             t2_strobe_i,
    input  logic             ext_clk_i,
    input  logic             ser_in_i,
    output logic             ser_out_o,
    output logic             done_o
);
    mode_dec_t dec;
    logic      ext_rise;
    logic      tick;

    assign dec = decode_mode(mode_i);

    shreg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(ext_clk_i),
        .rise_o (ext_rise)
    );

    shreg_tick_sel u_tick (
        .dec_i      (dec),
        .t2_strobe_i(t2_strobe_i),
        .ext_rise_i (ext_rise),
        .tick_o     (tick)
    );

    shreg_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst      (rst),
        .dec_i    (dec),
        .tick_i   (tick),
        .wr_en_i  (wr_en_i),
        .wr_data_i(wr_data_i),
        .rd_en_i  (rd_en_i),
        .ser_in_i (ser_in_i),
        .data_o   (rd_data_o),
        .ser_out_o(ser_out_o),
        .done_o   (done_o)
    );
endmodule

// File: rtl/shreg_shift_unit_chk.sv
module shreg_shift_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       mode_i,
    input logic             wr_en_i,
    input logic [WIDTH-1:0] wr_data_i,
    input logic             rd_en_i,
    input logic [WIDTH-1:0] rd_data_o,
    input logic             ser_in_i,
    input logic             ser_out_o,
    input logic             done_o
);
    assert_off_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd0 && !wr_en_i) |=> $stable(rd_data_o));

    assert_shift_in_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !rd_en_i && mode_i == 3'd2 && !done_o)
        |=> (rd_data_o == {$past(rd_data_o[WIDTH-2:0]), $past(ser_in_i)}));

    assert_shift_out_msb_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !rd_en_i && mode_i == 3'd6 && !done_o)
        |=> (ser_out_o == $past(rd_data_o[WIDTH-1])));

    assert_write_load_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (rd_data_o == $past(wr_data_i) && !done_o));

    assert_read_rearm_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !wr_en_i) |=> (!done_o && $stable(rd_data_o)));

    assert_stop_after_count_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && !wr_en_i && !rd_en_i && mode_i == 3'd2) |=> $stable(rd_data_o));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !wr_en_i && !rd_en_i) |=> done_o);
endmodule

bind shreg_shift_unit shreg_shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rd_en_i  (rd_en_i),
    .rd_data_o(rd_data_o),
    .ser_in_i (ser_in_i),
    .ser_out_o(ser_out_o),
    .done_o   (done_o)
);

// File: tb/shreg_shift_unit_tb.sv
module shreg_shift_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_i = 3'd0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       rd_en_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       t2_strobe_i = 1'b0;
    logic       ext_clk_i = 1'b0;
    logic       ser_in_i = 1'b0;
    logic       ser_out_o;
    logic       done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shreg_shift_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_en_i    (rd_en_i),
        .rd_data_o  (rd_data_o),
        .t2_strobe_i(t2_strobe_i),
        .ext_clk_i  (ext_clk_i),
        .ser_in_i   (ser_in_i),
        .ser_out_o  (ser_out_o),
        .done_o     (done_o)
    );

    // mode, write byte, serial-in pattern (first bit = bit 7), expected byte
    localparam logic [7:0] VEC [4][4] = '{
        '{8'd2, 8'hA5, 8'h3C, 8'h3C},
        '{8'd2, 8'hFF, 8'h00, 8'h00},
        '{8'd6, 8'h96, 8'h00, 8'h96},
        '{8'd6, 8'h01, 8'hFF, 8'h01}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en_i = 1'b1; wr_data_i = d;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic do_read();
        rd_en_i = 1'b1;
        step();
        rd_en_i = 1'b0;
    endtask

    task automatic strobe();
        t2_strobe_i = 1'b1;
        step();
        t2_strobe_i = 1'b0;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1 data", rd_data_o, 8'h00);
        check("R1 done", done_o, 1'b0);
        check("R1 ser_out", ser_out_o, 1'b0);

        // Table walk: system-clock modes
        for (int v = 0; v < 4; v++) begin
            mode_i = VEC[v][0][2:0];
            do_write(VEC[v][1]);
            check("R7 write load", rd_data_o, VEC[v][1]);
            for (int b = 0; b < 8; b++) begin
                ser_in_i = VEC[v][2][7-b];
                step();
                if (VEC[v][0] == 8'd6)
                    check("R4 serial bit", ser_out_o, VEC[v][1][7-b]);
                if (b == 6) check("R6 not yet done", done_o, 1'b0);
            end
            check("R3/R4 byte after 8", rd_data_o, VEC[v][3]);
            check("R6 done", done_o, 1'b1);
            ser_in_i = ~ser_in_i;
            step();
            check("R9 stopped", rd_data_o, VEC[v][3]);
        end

        // R2 mode 0 idle
        mode_i = 3'd0;
        do_write(8'h5A);
        ser_in_i = 1'b1; t2_strobe_i = 1'b1;
        for (int k = 0; k < 5; k++) begin
            ext_clk_i = ~ext_clk_i;
            step(2);
        end
        t2_strobe_i = 1'b0; ext_clk_i = 1'b0;
        check("R2 byte", rd_data_o, 8'h5A);
        check("R2 done", done_o, 1'b0);

        // R5 strobe mode 1
        mode_i = 3'd1;
        do_write(8'h00);
        ser_in_i = 1'b1;
        step(3);
        check("R5 no strobe no shift", rd_data_o, 8'h00);
        repeat (8) strobe();
        check("R3 strobe shift in", rd_data_o, 8'hFF);
        check("R6 strobe done", done_o, 1'b1);

        // R9 mode 4 stops
        mode_i = 3'd4;
        do_write(8'h80);
        repeat (8) strobe();
        check("R4 rotate back", rd_data_o, 8'h80);
        strobe();
        check("R9 mode4 stopped", rd_data_o, 8'h80);

        // R10 free-running mode 5
        mode_i = 3'd5;
        do_write(8'h81);
        repeat (8) strobe();
        check("R10 byte after 8", rd_data_o, 8'h81);
        strobe();
        check("R10 keeps rotating", rd_data_o, 8'h03);
        check("R10 done held", done_o, 1'b1);
        check("R10 ser_out", ser_out_o, 1'b1);

        // R8 read re-arms
        mode_i = 3'd2;
        do_write(8'h55);
        ser_in_i = 1'b0;
        step(8);
        check("R8 pre-read done", done_o, 1'b1);
        ser_in_i = 1'b1;
        do_read();
        check("R8 done cleared", done_o, 1'b0);
        check("R8 byte unchanged", rd_data_o, 8'h00);
        step(7);
        check("R8 seven shifts", done_o, 1'b0);
        step();
        check("R8 rearmed done", done_o, 1'b1);
        check("R8 byte after", rd_data_o, 8'hFF);

        // R7 write mid-count re-arms
        mode_i = 3'd6;
        do_write(8'hF0);
        step(4);
        do_write(8'h0F);
        step(7);
        check("R7 rearm seven", done_o, 1'b0);
        step();
        check("R7 rearm eight", done_o, 1'b1);
        check("R7 byte", rd_data_o, 8'h0F);

        // R5 external pin mode 3
        mode_i = 3'd3;
        do_write(8'h00);
        ser_in_i = 1'b1;
        ext_clk_i = 1'b1;
        step(2);
        check("R5 ext not yet", rd_data_o, 8'h00);
        step();
        check("R5 ext third edge", rd_data_o, 8'h01);
        ext_clk_i = 1'b0;
        step(4);
        check("R5 falling ignored", rd_data_o, 8'h01);
        ext_clk_i = 1'b1;
        step(3);
        check("R5 ext second rise", rd_data_o, 8'h03);

        // R5 external pin mode 7
        ext_clk_i = 1'b0;
        mode_i = 3'd7;
        step(3);
        do_write(8'h80);
        ext_clk_i = 1'b1;
        step(3);
        check("R4 ext out bit", ser_out_o, 1'b1);
        check("R4 ext out byte", rd_data_o, 8'h01);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule